// File: doc/BRIEF.md
# SMM Memory Region Access Guard

This block sits in a host bridge and guards a protected window at the top of installed DRAM that only System Management Mode code may touch. Software reaches two byte-wide control registers through a small configuration port. The first register holds the global enable, close, lock and open controls, plus a fixed read-only default. The second holds an SMM-only enable and a two-bit size code. Every CPU memory access is decoded combinationally against the window. The block reports whether the access hits the window, whether it is allowed, whether a write must be suppressed and whether a read must return all ones.

The lock behaves as a two-state machine, `ST_UNLOCKED` and `ST_LOCKED`. The only transition out of `ST_UNLOCKED` is ARM, taken by a configuration write of 1 to the lock bit. The only transition out of `ST_LOCKED` is reset, which returns the machine to `ST_UNLOCKED`. While the machine is locked, the open control is held at zero and the enables and the size are frozen. Installed RAM size and the extended window size are elaboration parameters.

Top module: `smm_region_guard`

## Requirements
- R1: After reset, the control register (`cfg_sel`=0) reads 0x02 and the extended register (`cfg_sel`=1) reads 0x00. Control register bits: [2:0] are fixed read-only 3'b010, [3] is the global enable, [4] is close, [5] is lock, [6] is open and [7] reads 0. Extended register bits: [0] is the SMM-only enable, [2:1] is the size code and the others read 0.
- R2: While unlocked, a write to the control register sets or clears open (bit 6) exactly as written.
- R3: A control write with bit 5 = 1 sets the lock and leaves open reading 0, even when the same write sets bit 6.
- R4: While locked, writes that try to set open leave it reading 0, and writes with bit 5 = 0 leave the lock set.
- R5: While locked, the global enable and the whole extended register ignore writes, and close still follows writes.
- R6: Reset clears the lock, after which open is writable again.
- R7: Size code 0, 1, 2 or 3 selects a window of 1 MB, 2 MB, 8 MB or EXT_MB MB. The window spans from (RAM_MB - size) x 2^20 up to RAM_MB x 2^20 - 1.
- R8: The window is enforced only when the global enable and the SMM-only enable are both 1. Otherwise `mem_hit` stays 0.
- R9: A non-SMM read inside an enforced window gives `mem_hit`=1, `mem_allow`=0 and `mem_rd_force_ff`=1, so the read data is forced to 0xFF.
- R10: A non-SMM write inside an enforced window gives `mem_we_suppress`=1 and `mem_allow`=0.
- R11: The byte at base - 1 is ordinary memory: no hit, allowed, and no suppress flag.
- R12: An SMM access inside the window is allowed, unless close is 1 and the access is a data access (`mem_is_data`=1). Such an access is blocked like a non-SMM access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Register select: 0 control, 1 extended |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Read data of the selected register (combinational) |
| mem_valid | input | 1 | CPU memory access present |
| mem_addr | input | ADDR_W | Byte address of the access |
| mem_we | input | 1 | Access is a write |
| mem_smm | input | 1 | CPU is in SMM |
| mem_is_data | input | 1 | 1 for a data access, 0 for an instruction fetch |
| mem_hit | output | 1 | Access falls in the enforced window |
| mem_allow | output | 1 | Access may proceed to DRAM |
| mem_we_suppress | output | 1 | Drop this write |
| mem_rd_force_ff | output | 1 | Return 0xFF for this read |

## Verification
The assertions check several rules on every cycle. The lock is sticky and open stays cleared while locked. The extended register holds still once locked. A suppress flag only ever accompanies a write that hits, and a disabled window never reports a hit. The bench scenarios are needed to show the exact window base for each size code and the ordinary behaviour of the byte just below it. They also show the per-bit write masking while locked, and that reset lets open be written again.

// File: rtl/smm_guard_pkg.sv
package smm_guard_pkg;

    typedef enum logic [0:0] {
        ST_UNLOCKED = 1'b0,
        ST_LOCKED   = 1'b1
    } lock_state_e;

    localparam int unsigned CTL_GEN_BIT   = 3;
    localparam int unsigned CTL_CLOSE_BIT = 4;
    localparam int unsigned CTL_LOCK_BIT  = 5;
    localparam int unsigned CTL_OPEN_BIT  = 6;
    localparam logic [2:0]  CTL_FIXED_LOW = 3'b010;

    // window size in MB for a size code; code 3 escapes to the extended value
    function automatic int unsigned window_mb(input logic [1:0] code,
                                              input int unsigned ext_mb);
        unique case (code)
            2'd0:    return 1;
            2'd1:    return 2;
            2'd2:    return 8;
            default: return ext_mb;
        endcase
    endfunction

endpackage

// File: rtl/smm_guard_regs.sv
module smm_guard_regs
    import smm_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_we,
    input  logic       cfg_sel,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] cfg_rdata,
    output logic       gen_en,
    output logic       close_q,
    output logic       smm_only,
    output logic [1:0] size_code
);

    lock_state_e state_q, state_d;
    logic        open_q;

    logic ctl_wr, ext_wr;
    assign ctl_wr = cfg_we && !cfg_sel;
    assign ext_wr = cfg_we && cfg_sel;

    // next-state logic of the lock machine
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_UNLOCKED: if (ctl_wr && cfg_wdata[CTL_LOCK_BIT]) state_d = ST_LOCKED;
            ST_LOCKED:   state_d = ST_LOCKED;
            default:     state_d = ST_UNLOCKED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_UNLOCKED;
        else     state_q <= state_d;
    end

    // field registers
    always_ff @(posedge clk) begin
        if (rst) begin
            open_q    <= 1'b0;
            close_q   <= 1'b0;
            gen_en    <= 1'b0;
            smm_only  <= 1'b0;
            size_code <= 2'd0;
        end else begin
            if (ctl_wr) begin
                close_q <= cfg_wdata[CTL_CLOSE_BIT];
                if (state_q == ST_UNLOCKED) begin
                    gen_en <= cfg_wdata[CTL_GEN_BIT];
                    open_q <= cfg_wdata[CTL_OPEN_BIT] && !cfg_wdata[CTL_LOCK_BIT];
                end else begin
                    open_q <= 1'b0;
                end
            end
            if (ext_wr && state_q == ST_UNLOCKED) begin
                smm_only  <= cfg_wdata[0];
                size_code <= cfg_wdata[2:1];
            end
        end
    end

    // read output process
    always_comb begin
        if (cfg_sel) begin
            cfg_rdata = {5'b0, size_code, smm_only};
        end else begin
            cfg_rdata = {1'b0, open_q, (state_q == ST_LOCKED), close_q, gen_en, CTL_FIXED_LOW};
        end
    end

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_LOCKED |=> state_q == ST_LOCKED); // R4
    AST_OPEN_HELD_LOW: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_LOCKED |-> !open_q); // R3
    AST_EXT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        state_q == ST_LOCKED |=> $stable(size_code) && $stable(smm_only) && $stable(gen_en)); // R5

endmodule

// File: rtl/smm_guard_decode.sv
module smm_guard_decode
    import smm_guard_pkg::*;
#(
    parameter int unsigned RAM_MB = 128,
    parameter int unsigned EXT_MB = 16,
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              gen_en,
    input  logic              close_q,
    input  logic              smm_only,
    input  logic [1:0]        size_code,
    input  logic              mem_valid,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_we,
    input  logic              mem_smm,
    input  logic              mem_is_data,
    output logic              mem_hit,
    output logic              mem_allow,
    output logic              mem_we_suppress,
    output logic              mem_rd_force_ff
);

    localparam logic [ADDR_W-1:0] TOP_ADDR = ADDR_W'(RAM_MB) << 20;

    logic [ADDR_W-1:0] base;
    logic              enforced, in_win, blocked;

    always_comb begin
        base     = ADDR_W'(RAM_MB - window_mb(size_code, EXT_MB)) << 20;
        enforced = gen_en && smm_only;
        in_win   = enforced && (mem_addr >= base) && (mem_addr < TOP_ADDR);
        blocked  = mem_smm ? (close_q && mem_is_data) : 1'b1;
        mem_hit         = mem_valid && in_win;
        mem_allow       = !(mem_hit && blocked);
        mem_we_suppress = mem_hit && blocked && mem_we;
        mem_rd_force_ff = mem_hit && blocked && !mem_we;
    end

    AST_SUPPRESS_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        mem_we_suppress |-> mem_we && mem_hit && !mem_allow); // R10
    AST_NONSMM_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        mem_hit && !mem_smm |-> !mem_allow); // R9
    AST_BELOW_BASE: assert property (@(posedge clk) disable iff (rst)
        mem_valid && mem_addr < base |-> !mem_hit && mem_allow); // R11
    AST_SMM_FETCH_OK: assert property (@(posedge clk) disable iff (rst)
        mem_smm && !mem_is_data |-> mem_allow); // R12
    AST_NO_ENFORCE: assert property (@(posedge clk) disable iff (rst)
        !(gen_en && smm_only) |-> !mem_hit); // R8

endmodule

// File: rtl/smm_region_guard.sv
module smm_region_guard #(
    parameter int unsigned RAM_MB = 128,
    parameter int unsigned EXT_MB = 16,
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [7:0]        cfg_wdata,
    output logic [7:0]        cfg_rdata,
    input  logic              mem_valid,
    input  logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_we,
    input  logic              mem_smm,
    input  logic              mem_is_data,
    output logic              mem_hit,
    output logic              mem_allow,
    output logic              mem_we_suppress,
    output logic              mem_rd_force_ff
);

    logic       gen_en, close_q, smm_only;
    logic [1:0] size_code;

    smm_guard_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .gen_en    (gen_en),
        .close_q   (close_q),
        .smm_only  (smm_only),
        .size_code (size_code)
    );

    smm_guard_decode #(
        .RAM_MB (RAM_MB),
        .EXT_MB (EXT_MB),
        .ADDR_W (ADDR_W)
    ) u_decode (
        .clk             (clk),
        .rst             (rst),
        .gen_en          (gen_en),
        .close_q         (close_q),
        .smm_only        (smm_only),
        .size_code       (size_code),
        .mem_valid       (mem_valid),
        .mem_addr        (mem_addr),
        .mem_we          (mem_we),
        .mem_smm         (mem_smm),
        .mem_is_data     (mem_is_data),
        .mem_hit         (mem_hit),
        .mem_allow       (mem_allow),
        .mem_we_suppress (mem_we_suppress),
        .mem_rd_force_ff (mem_rd_force_ff)
    );

endmodule

// File: tb/sim_smm_region_guard.sv
`timescale 1ns/1ps
module sim_smm_region_guard;

    localparam int unsigned RAM_MB = 128;
    localparam int unsigned EXT_MB = 16;
    localparam int unsigned ADDR_W = 32;
    localparam int NVEC = 18;

    // {code[1:0], where[1:0] (0 base-1, 1 base, 2 top-1), we, smm, data, close, hit, sup, ff}
    localparam logic [10:0] VEC [0:NVEC-1] = '{
        {2'd0, 2'd0, 4'b0011, 3'b000}, {2'd0, 2'd1, 4'b0011, 3'b101},
        {2'd0, 2'd1, 4'b1011, 3'b110}, {2'd0, 2'd2, 4'b0110, 3'b100},
        {2'd1, 2'd0, 4'b0011, 3'b000}, {2'd1, 2'd1, 4'b0011, 3'b101},
        {2'd1, 2'd1, 4'b1011, 3'b110}, {2'd1, 2'd2, 4'b0110, 3'b100},
        {2'd2, 2'd0, 4'b0011, 3'b000}, {2'd2, 2'd1, 4'b0011, 3'b101},
        {2'd2, 2'd1, 4'b1011, 3'b110}, {2'd2, 2'd2, 4'b0110, 3'b100},
        {2'd3, 2'd0, 4'b0011, 3'b000}, {2'd3, 2'd1, 4'b0011, 3'b101},
        {2'd3, 2'd1, 4'b1011, 3'b110}, {2'd3, 2'd2, 4'b0110, 3'b100},
        {2'd3, 2'd1, 4'b0111, 3'b101}, {2'd3, 2'd1, 4'b0101, 3'b100}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_we = 1'b0;
    logic              cfg_sel = 1'b0;
    logic [7:0]        cfg_wdata = 8'h00;
    logic [7:0]        cfg_rdata;
    logic              mem_valid = 1'b0;
    logic [ADDR_W-1:0] mem_addr = '0;
    logic              mem_we = 1'b0;
    logic              mem_smm = 1'b0;
    logic              mem_is_data = 1'b0;
    logic              mem_hit, mem_allow, mem_we_suppress, mem_rd_force_ff;

    int applied = 0;
    int miscompares = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    smm_region_guard #(.RAM_MB(RAM_MB), .EXT_MB(EXT_MB), .ADDR_W(ADDR_W)) u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_smm(mem_smm), .mem_is_data(mem_is_data),
        .mem_hit(mem_hit), .mem_allow(mem_allow),
        .mem_we_suppress(mem_we_suppress), .mem_rd_force_ff(mem_rd_force_ff)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        applied++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic cfg_wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        cfg_sel = sel; cfg_wdata = d; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_rd(input logic sel, output logic [7:0] d);
        @(negedge clk);
        cfg_sel = sel;
        #1 d = cfg_rdata;
    endtask

    function automatic int unsigned size_of(input logic [1:0] c);
        case (c)
            2'd0: return 1;
            2'd1: return 2;
            2'd2: return 8;
            default: return EXT_MB;
        endcase
    endfunction

    task automatic access(input logic [ADDR_W-1:0] a, input logic we, input logic smm,
                          input logic dat);
        @(negedge clk);
        mem_valid = 1'b1; mem_addr = a; mem_we = we; mem_smm = smm; mem_is_data = dat;
        #1;
    endtask

    initial begin
        #(20ns * 200000);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        do_reset();

        // R1 reset values
        cfg_rd(1'b0, rd); check("R1 ctl reset", rd, 8'h02);
        cfg_rd(1'b1, rd); check("R1 ext reset", rd, 8'h00);

        // R2 open freely writable while unlocked
        cfg_wr(1'b0, 8'h42); cfg_rd(1'b0, rd); check("R2 open set", rd, 8'h42);
        cfg_wr(1'b0, 8'h02); cfg_rd(1'b0, rd); check("R2 open clear", rd, 8'h02);

        // R7 R9 R10 R11 R12 vector table
        for (int i = 0; i < NVEC; i++) begin
            logic [1:0] code;
            logic [1:0] where;
            logic [ADDR_W-1:0] base_a, addr;
            code  = VEC[i][10:9];
            where = VEC[i][8:7];
            do_reset();
            cfg_wr(1'b1, {5'b0, code, 1'b1});
            cfg_wr(1'b0, 8'h0A | (VEC[i][3] ? 8'h10 : 8'h00));
            base_a = ADDR_W'(RAM_MB - size_of(code)) << 20;
            case (where)
                2'd0:    addr = base_a - 1;
                2'd1:    addr = base_a;
                default: addr = (ADDR_W'(RAM_MB) << 20) - 1;
            endcase
            access(addr, VEC[i][6], VEC[i][5], VEC[i][4]);
            check($sformatf("R7/R11 hit vec%0d", i), {7'b0, mem_hit}, {7'b0, VEC[i][2]});
            check($sformatf("R10 suppress vec%0d", i), {7'b0, mem_we_suppress}, {7'b0, VEC[i][1]});
            check($sformatf("R9/R12 force_ff vec%0d", i), {7'b0, mem_rd_force_ff}, {7'b0, VEC[i][0]});
            check($sformatf("R12 allow vec%0d", i), {7'b0, mem_allow},
                  {7'b0, !(VEC[i][1] || VEC[i][0])});
            mem_valid = 1'b0;
        end

        // R8 enforcement needs both enables
        do_reset();
        cfg_wr(1'b1, 8'h01); cfg_wr(1'b0, 8'h02);
        access((ADDR_W'(RAM_MB) << 20) - 1, 1'b0, 1'b0, 1'b1);
        check("R8 gen off", {7'b0, mem_hit}, 8'h00);
        cfg_wr(1'b1, 8'h00); cfg_wr(1'b0, 8'h0A);
        access((ADDR_W'(RAM_MB) << 20) - 1, 1'b0, 1'b0, 1'b1);
        check("R8 smm-only off", {7'b0, mem_hit}, 8'h00);
        mem_valid = 1'b0;

        // R3 lock write clears open
        do_reset();
        cfg_wr(1'b1, 8'h03);
        cfg_wr(1'b0, 8'h4A); cfg_rd(1'b0, rd); check("R2 open before lock", rd, 8'h4A);
        cfg_wr(1'b0, 8'h6A); cfg_rd(1'b0, rd); check("R3 lock clears open", rd, 8'h2A);
        // R4 open and lock frozen
        cfg_wr(1'b0, 8'h4A); cfg_rd(1'b0, rd); check("R4 open stays 0, lock stays", rd, 8'h2A);
        // R5 enables and size frozen, close writable
        cfg_wr(1'b1, 8'h04); cfg_rd(1'b1, rd); check("R5 ext frozen", rd, 8'h03);
        cfg_wr(1'b0, 8'h12); cfg_rd(1'b0, rd); check("R5 gen frozen close writes", rd, 8'h3A);
        // R9 locked 2 MB window still enforced
        access(ADDR_W'(RAM_MB - 2) << 20, 1'b0, 1'b0, 1'b1);
        check("R9 locked window read", {7'b0, mem_rd_force_ff}, 8'h01);
        mem_valid = 1'b0;

        // R6 reset releases lock
        do_reset();
        cfg_rd(1'b0, rd); check("R6 lock cleared", rd, 8'h02);
        cfg_wr(1'b0, 8'h42); cfg_rd(1'b0, rd); check("R6 open writable", rd, 8'h42);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end

endmodule